// File: doc/BRIEF.md
# Texture Request Sequencer

This block sits between a shader core and a texture fetch unit. The shader issues a texture access by writing coordinate registers one at a time (S, T, R, B). Each accepted write takes the next configuration word from an internal uniform queue and stores the coordinate, the register it targeted and that word as one entry of a request queue, which the fetch unit drains. The write to S closes the request, so an access of one, two, three or four configuration words (1D buffer, 2D texture, cubemap, child image) is always finished with S.

The first word of each request is decoded into an image base address (4 KiB aligned), a mip level count and a cache swizzle mode. Every entry of that request carries these fields to the fetch unit. Back-pressure reaches the shader through a single ready signal. This signal drops when the request queue is full, when no configuration word is waiting, or, in two-thread mode, when the writing thread already holds half of the request queue. Texture results come back in issue order into a response queue, and the shader takes the oldest one with a read strobe.

Top module: `tex_req_seq`

## Requirements
- R1: After reset, wr_ready_o, req_valid_o and rd_valid_o are 0, req_level_o is 0 and uni_ready_o is 1.
- R2: Each accepted write (wr_valid_i and wr_ready_o high at a clock edge) removes exactly one configuration word from the uniform queue, oldest first. It adds one request entry holding wr_data_i, the register code (S=0, T=1, R=2, B=3) and that word. Entries leave in write order.
- R3: An entry is marked launch exactly when its register code is S. req_nwords_o of each entry counts the writes of its request up to and including that entry, so a launch entry shows the full word count (1 to 4).
- R4: The entry after a launch, or the first after reset, is marked first. Every entry of a request shows the fields of that first word: req_base_o = word[31:12] shifted left by 12, req_mips_o = word[3:0] + 1, req_swz_o = word[11:10].
- R5: With 8 entries queued, wr_ready_o is 0. A write held during the stall is not dropped. It is accepted once an entry drains, and it keeps its own data.
- R6: With the uniform queue empty, wr_ready_o is 0 and the write is not taken. It completes after a word arrives.
- R7: With dual_i high, a thread that holds 4 entries is stalled, and a write from the other thread is still accepted.
- R8: req_level_o equals the number of queued request entries.
- R9: rd_data_o shows the oldest unread response while rd_valid_o is 1. rd_i removes it. rd_valid_o is 0 when none is left. rsp_ready_o is 0 when 8 responses are held.
- R10: Requests of the two threads may be written interleaved. Each thread keeps its own first-word fields and word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| uni_valid_i | input | 1 | Configuration word offered to the uniform queue |
| uni_data_i | input | 32 | Configuration word |
| uni_ready_o | output | 1 | Uniform queue has room |
| dual_i | input | 1 | Two-thread mode, halves the per-thread share |
| wr_valid_i | input | 1 | Shader writes a coordinate register |
| wr_thread_i | input | 1 | Writing thread |
| wr_sel_i | input | 2 | Register code S=0 T=1 R=2 B=3 |
| wr_data_i | input | 32 | Coordinate value |
| wr_ready_o | output | 1 | Write accepted this cycle |
| req_valid_o | output | 1 | Request entry available |
| req_ready_i | input | 1 | Fetch unit takes the entry |
| req_sel_o | output | 2 | Register code of the entry |
| req_coord_o | output | 32 | Coordinate value |
| req_cfg_o | output | 32 | Configuration word paired with it |
| req_first_o | output | 1 | First entry of a request |
| req_launch_o | output | 1 | Entry closes and launches the request |
| req_nwords_o | output | 3 | Writes of the request so far |
| req_thread_o | output | 1 | Thread that wrote the entry |
| req_base_o | output | 32 | Image byte base address |
| req_mips_o | output | 5 | Number of mip levels |
| req_swz_o | output | 2 | Cache swizzle mode |
| req_level_o | output | 4 | Request queue occupancy |
| rsp_valid_i | input | 1 | Returned texture data |
| rsp_data_i | input | 32 | Returned word |
| rsp_ready_o | output | 1 | Response queue has room |
| rd_i | input | 1 | Shader reads the oldest response |
| rd_valid_o | output | 1 | A response is waiting |
| rd_data_o | output | 32 | Oldest response |

## Verification
The hardest state to reach is a write that is already stalled when room appears. The stimulus has to fill the request queue to 8 with the fetch side held off, then keep a ninth write pending over several cycles while a concurrent process drains one entry. That ninth entry must appear at the tail with its own data. The per-thread limit needs the same set-up in two-thread mode, and the bench switches the pending write to the other thread. The decode sweep walks 64 requests that cover every mip count and swizzle value and all four request lengths.

// File: rtl/tex_req_pkg.sv
package tex_req_pkg;
  localparam int WORD_W = 32;
  localparam int BASE_W = 20;
  localparam int MIP_W  = 5;
  localparam int SWZ_W  = 2;
  localparam int NW_W   = 3;

  typedef enum logic [1:0] {
    REG_S = 2'd0,
    REG_T = 2'd1,
    REG_R = 2'd2,
    REG_B = 2'd3
  } tex_reg_e;

  typedef struct packed {
    logic [WORD_W-1:0] coord;
    logic [WORD_W-1:0] cfg;
    tex_reg_e          sel;
    logic              first;
    logic              launch;
    logic [NW_W-1:0]   nwords;
    logic              thread;
    logic [BASE_W-1:0] base;
    logic [MIP_W-1:0]  mips;
    logic [SWZ_W-1:0]  swz;
  } tex_req_t;
endpackage

// File: rtl/tex_fifo.sv
module tex_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CW'(DEPTH));
  assign count_o = cnt;
  assign data_o  = mem[rd_ptr];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      if (do_push && !do_pop)      cnt <= cnt + CW'(1);
      else if (do_pop && !do_push) cnt <= cnt - CW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= data_i;
  end
endmodule

// File: rtl/tex_cfg_decode.sv
module tex_cfg_decode
  import tex_req_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic [BASE_W-1:0] base_o,
  output logic [MIP_W-1:0]  mips_o,
  output logic [SWZ_W-1:0]  swz_o
);
  assign base_o = word_i[31:12];
  assign swz_o  = word_i[11:10];
  assign mips_o = {1'b0, word_i[3:0]} + MIP_W'(1);
endmodule

// File: rtl/tex_req_seq.sv
module tex_req_seq
  import tex_req_pkg::*;
#(
  parameter int REQ_DEPTH = 8,
  parameter int UNI_DEPTH = 16,
  parameter int RSP_DEPTH = 8,
  localparam int HALF     = REQ_DEPTH / 2,
  localparam int LW       = $clog2(REQ_DEPTH + 1),
  localparam int UW       = $clog2(UNI_DEPTH + 1),
  localparam int RW       = $clog2(RSP_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              uni_valid_i,
  input  logic [WORD_W-1:0] uni_data_i,
  output logic              uni_ready_o,
  input  logic              dual_i,
  input  logic              wr_valid_i,
  input  logic              wr_thread_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              wr_ready_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [1:0]        req_sel_o,
  output logic [WORD_W-1:0] req_coord_o,
  output logic [WORD_W-1:0] req_cfg_o,
  output logic              req_first_o,
  output logic              req_launch_o,
  output logic [NW_W-1:0]   req_nwords_o,
  output logic              req_thread_o,
  output logic [WORD_W-1:0] req_base_o,
  output logic [MIP_W-1:0]  req_mips_o,
  output logic [SWZ_W-1:0]  req_swz_o,
  output logic [LW-1:0]     req_level_o,
  input  logic              rsp_valid_i,
  input  logic [WORD_W-1:0] rsp_data_i,
  output logic              rsp_ready_o,
  input  logic              rd_i,
  output logic              rd_valid_o,
  output logic [WORD_W-1:0] rd_data_o
);
  // uniform queue
  logic [WORD_W-1:0] uni_head;
  logic              uni_empty, uni_full;
  logic [UW-1:0]     uni_cnt;
  logic              wr_fire;

  tex_fifo #(.W(WORD_W), .DEPTH(UNI_DEPTH)) u_uni (
    .clk_i, .rst_ni,
    .push_i (uni_valid_i),
    .data_i (uni_data_i),
    .pop_i  (wr_fire),
    .data_o (uni_head),
    .empty_o(uni_empty),
    .full_o (uni_full),
    .count_o(uni_cnt)
  );
  assign uni_ready_o = !uni_full;

  logic [BASE_W-1:0] dec_base;
  logic [MIP_W-1:0]  dec_mips;
  logic [SWZ_W-1:0]  dec_swz;

  tex_cfg_decode u_dec (
    .word_i(uni_head), .base_o(dec_base), .mips_o(dec_mips), .swz_o(dec_swz)
  );

  // request queue
  tex_req_t      req_in, req_head;
  logic          req_empty, req_full, req_pop;
  logic [LW-1:0] req_cnt;

  tex_fifo #(.W($bits(tex_req_t)), .DEPTH(REQ_DEPTH)) u_req (
    .clk_i, .rst_ni,
    .push_i (wr_fire),
    .data_i (req_in),
    .pop_i  (req_pop),
    .data_o (req_head),
    .empty_o(req_empty),
    .full_o (req_full),
    .count_o(req_cnt)
  );

  // per-thread assembly state
  logic              first_v [2];
  logic [NW_W-1:0]   nw_v    [2];
  logic [BASE_W-1:0] base_v  [2];
  logic [MIP_W-1:0]  mips_v  [2];
  logic [SWZ_W-1:0]  swz_v   [2];
  logic [LW-1:0]     thr_cnt [2];
  logic [LW-1:0]     thr_cnt0, thr_cnt1;
  logic              thr_ok, is_launch, cur_first;
  logic [NW_W-1:0]   cur_nw;

  assign is_launch = (tex_reg_e'(wr_sel_i) == REG_S);
  assign cur_first = first_v[wr_thread_i];
  assign cur_nw    = (nw_v[wr_thread_i] == '1) ? '1 : nw_v[wr_thread_i] + NW_W'(1);
  assign thr_ok    = !dual_i || (thr_cnt[wr_thread_i] < LW'(HALF));
  assign wr_ready_o = !uni_empty && !req_full && thr_ok;
  assign wr_fire    = wr_valid_i && wr_ready_o;
  assign req_pop    = req_valid_o && req_ready_i;
  assign thr_cnt0   = thr_cnt[0];
  assign thr_cnt1   = thr_cnt[1];

  always_comb begin
    req_in.coord  = wr_data_i;
    req_in.cfg    = uni_head;
    req_in.sel    = tex_reg_e'(wr_sel_i);
    req_in.first  = cur_first;
    req_in.launch = is_launch;
    req_in.nwords = cur_nw;
    req_in.thread = wr_thread_i;
    req_in.base   = cur_first ? dec_base : base_v[wr_thread_i];
    req_in.mips   = cur_first ? dec_mips : mips_v[wr_thread_i];
    req_in.swz    = cur_first ? dec_swz  : swz_v[wr_thread_i];
  end

  for (genvar t = 0; t < 2; t++) begin : g_thr
    logic              mine, inc, dec;
    logic              first_q;
    logic [NW_W-1:0]   nw_q;
    logic [BASE_W-1:0] base_q;
    logic [MIP_W-1:0]  mips_q;
    logic [SWZ_W-1:0]  swz_q;
    logic [LW-1:0]     cnt_q;

    assign mine = wr_fire && (wr_thread_i == 1'(t));
    assign inc  = mine;
    assign dec  = req_pop && (req_head.thread == 1'(t));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        first_q <= 1'b1;
        nw_q    <= '0;
        base_q  <= '0;
        mips_q  <= '0;
        swz_q   <= '0;
        cnt_q   <= '0;
      end else begin
        if (mine) begin
          first_q <= is_launch;
          nw_q    <= is_launch ? '0 : cur_nw;
          if (first_q) begin
            base_q <= dec_base;
            mips_q <= dec_mips;
            swz_q  <= dec_swz;
          end
        end
        if (inc && !dec)      cnt_q <= cnt_q + LW'(1);
        else if (dec && !inc) cnt_q <= cnt_q - LW'(1);
      end
    end

    assign first_v[t] = first_q;
    assign nw_v[t]    = nw_q;
    assign base_v[t]  = base_q;
    assign mips_v[t]  = mips_q;
    assign swz_v[t]   = swz_q;
    assign thr_cnt[t] = cnt_q;
  end

  assign req_valid_o  = !req_empty;
  assign req_sel_o    = req_head.sel;
  assign req_coord_o  = req_head.coord;
  assign req_cfg_o    = req_head.cfg;
  assign req_first_o  = req_head.first;
  assign req_launch_o = req_head.launch;
  assign req_nwords_o = req_head.nwords;
  assign req_thread_o = req_head.thread;
  assign req_base_o   = {req_head.base, 12'b0};
  assign req_mips_o   = req_head.mips;
  assign req_swz_o    = req_head.swz;
  assign req_level_o  = req_cnt;

  // response queue
  logic          rsp_empty, rsp_full;
  logic [RW-1:0] rsp_cnt;

  tex_fifo #(.W(WORD_W), .DEPTH(RSP_DEPTH)) u_rsp (
    .clk_i, .rst_ni,
    .push_i (rsp_valid_i),
    .data_i (rsp_data_i),
    .pop_i  (rd_i),
    .data_o (rd_data_o),
    .empty_o(rsp_empty),
    .full_o (rsp_full),
    .count_o(rsp_cnt)
  );
  assign rsp_ready_o = !rsp_full;
  assign rd_valid_o  = !rsp_empty;
endmodule

// File: rtl/tex_req_seq_chk.sv
module tex_req_seq_chk #(
  parameter int REQ_DEPTH = 8,
  localparam int HALF     = REQ_DEPTH / 2,
  localparam int LW       = $clog2(REQ_DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          dual_i,
  input logic          wr_valid_i,
  input logic          wr_thread_i,
  input logic          wr_ready_o,
  input logic          uni_empty,
  input logic [LW-1:0] thr_cnt0,
  input logic [LW-1:0] thr_cnt1,
  input logic          req_valid_o,
  input logic          req_ready_i,
  input logic          req_launch_o,
  input logic [2:0]    req_nwords_o,
  input logic [LW-1:0] req_level_o,
  input logic          rsp_valid_i,
  input logic          rsp_ready_o,
  input logic          rd_valid_o
);
  a_r5_full_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_level_o == LW'(REQ_DEPTH) |-> !wr_ready_o);

  a_r6_uni_empty_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uni_empty |-> !wr_ready_o);

  a_r7_thread_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dual_i && wr_valid_i && wr_ready_o |-> ((wr_thread_i ? thr_cnt1 : thr_cnt0) < LW'(HALF)));

  a_r8_level_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && wr_ready_o && !(req_valid_o && req_ready_i)
    |=> req_level_o == $past(req_level_o) + LW'(1));

  a_r8_level_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_valid_i && wr_ready_o) && req_valid_o && req_ready_i
    |=> req_level_o == $past(req_level_o) - LW'(1));

  a_r3_launch_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_launch_o |-> req_nwords_o != 3'd0);

  a_r9_rsp_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i && rsp_ready_o |=> rd_valid_o);
endmodule

bind tex_req_seq tex_req_seq_chk #(.REQ_DEPTH(REQ_DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dual_i      (dual_i),
  .wr_valid_i  (wr_valid_i),
  .wr_thread_i (wr_thread_i),
  .wr_ready_o  (wr_ready_o),
  .uni_empty   (uni_empty),
  .thr_cnt0    (thr_cnt0),
  .thr_cnt1    (thr_cnt1),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_launch_o(req_launch_o),
  .req_nwords_o(req_nwords_o),
  .req_level_o (req_level_o),
  .rsp_valid_i (rsp_valid_i),
  .rsp_ready_o (rsp_ready_o),
  .rd_valid_o  (rd_valid_o)
);

// File: tb/tex_req_seq_bench.sv
module tex_req_seq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        uni_valid_i = 1'b0;
  logic [31:0] uni_data_i = '0;
  logic        uni_ready_o;
  logic        dual_i = 1'b0;
  logic        wr_valid_i = 1'b0;
  logic        wr_thread_i = 1'b0;
  logic [1:0]  wr_sel_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        wr_ready_o;
  logic        req_valid_o;
  logic        req_ready_i = 1'b0;
  logic [1:0]  req_sel_o;
  logic [31:0] req_coord_o, req_cfg_o, req_base_o;
  logic        req_first_o, req_launch_o, req_thread_o;
  logic [2:0]  req_nwords_o;
  logic [4:0]  req_mips_o;
  logic [1:0]  req_swz_o;
  logic [3:0]  req_level_o;
  logic        rsp_valid_i = 1'b0;
  logic [31:0] rsp_data_i = '0;
  logic        rsp_ready_o;
  logic        rd_i = 1'b0;
  logic        rd_valid_o;
  logic [31:0] rd_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  tex_req_seq u_tex_req_seq (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_uni(input logic [31:0] w);
    @(negedge clk_i);
    uni_valid_i = 1'b1;
    uni_data_i  = w;
    @(posedge clk_i); #1;
    uni_valid_i = 1'b0;
  endtask

  task automatic do_wr(input logic t, input logic [1:0] sel, input logic [31:0] c);
    int n;
    @(negedge clk_i);
    wr_valid_i = 1'b1; wr_thread_i = t; wr_sel_i = sel; wr_data_i = c;
    n = 0;
    #1;
    while (!wr_ready_o && n < 60) begin
      @(negedge clk_i); #1; n++;
    end
    @(posedge clk_i); #1;
    wr_valid_i = 1'b0;
  endtask

  task automatic pop_chk(input string tag, input logic [1:0] sel, input logic [31:0] c,
                         input logic [31:0] cfg, input logic first, input logic launch,
                         input logic [2:0] nw, input logic thr, input logic [31:0] base,
                         input logic [4:0] mips, input logic [1:0] swz);
    @(negedge clk_i);
    req_ready_i = 1'b1;
    #1;
    chk(req_valid_o == 1'b1, {tag, " R2 valid"}, req_valid_o, 1);
    chk(req_sel_o == sel && req_coord_o == c && req_cfg_o == cfg,
        {tag, " R2 sel/coord/cfg"}, {req_sel_o, req_coord_o}, {sel, c});
    chk(req_cfg_o == cfg, {tag, " R2 cfg"}, req_cfg_o, cfg);
    chk(req_first_o == first && req_launch_o == launch && req_nwords_o == nw,
        {tag, " R3 first/launch/nwords"}, {req_first_o, req_launch_o, req_nwords_o},
        {first, launch, nw});
    chk(req_thread_o == thr, {tag, " R10 thread"}, req_thread_o, thr);
    chk(req_base_o == base && req_mips_o == mips && req_swz_o == swz,
        {tag, " R4 decode"}, {req_base_o, req_mips_o, req_swz_o}, {base, mips, swz});
    @(posedge clk_i); #1;
    req_ready_i = 1'b0;
  endtask

  function automatic logic [1:0] sel_of(input int j, input int n);
    if (j == n - 1) return 2'd0;
    return (j == 0) ? 2'd1 : (j == 1) ? 2'd2 : 2'd3;
  endfunction

  initial begin
    #(100_000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] w0, wa, wb;
    // R1 reset state
    #22;
    chk(wr_ready_o == 0 && req_valid_o == 0 && rd_valid_o == 0, "R1 flags in reset",
        {wr_ready_o, req_valid_o, rd_valid_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk(req_level_o == 0, "R1 level", req_level_o, 0);
    chk(uni_ready_o == 1 && wr_ready_o == 0, "R1 ready", {uni_ready_o, wr_ready_o}, 2'b10);

    // R2 R3 R4 R8 sweep: 64 requests over lengths, mip counts, swizzles
    for (int k = 0; k < 64; k++) begin
      int n;
      logic [19:0] b20;
      logic [3:0] mp;
      logic [1:0] sw;
      n   = (k % 4) + 1;
      mp  = 4'(k % 16);
      sw  = 2'(k / 16);
      b20 = 20'((k * 32'h2345 + 32'h100) & 32'hFFFFF);
      w0  = {b20, sw, 2'b01, 4'(k) ^ 4'h5, mp};
      for (int j = 0; j < n; j++)
        push_uni(j == 0 ? w0 : (32'hA500_0000 | 32'(k << 8) | 32'(j)));
      for (int j = 0; j < n; j++)
        do_wr(1'b0, sel_of(j, n), 32'h3F00_0000 + 32'(k * 16 + j));
      #1;
      chk(req_level_o == 4'(n), "R8 level after request", req_level_o, n);
      for (int j = 0; j < n; j++)
        pop_chk("sweep", sel_of(j, n), 32'h3F00_0000 + 32'(k * 16 + j),
                j == 0 ? w0 : (32'hA500_0000 | 32'(k << 8) | 32'(j)),
                j == 0, j == n - 1, 3'(j + 1), 1'b0, {b20, 12'b0},
                5'(mp) + 5'd1, sw);
    end

    // R6 uniform empty stalls, then completes
    @(negedge clk_i);
    wr_valid_i = 1'b1; wr_thread_i = 1'b0; wr_sel_i = 2'd0; wr_data_i = 32'h1234_5678;
    #1;
    chk(wr_ready_o == 0, "R6 stall when uniform empty", wr_ready_o, 0);
    repeat (2) @(negedge clk_i);
    #1;
    chk(req_level_o == 0, "R6 write not taken", req_level_o, 0);
    w0 = 32'h0004_2C03;
    push_uni(w0);
    @(negedge clk_i); #1;
    chk(wr_ready_o == 1, "R6 ready after word", wr_ready_o, 1);
    @(posedge clk_i); #1;
    wr_valid_i = 1'b0;
    pop_chk("R6", 2'd0, 32'h1234_5678, w0, 1, 1, 3'd1, 0, 32'h0004_2000, 5'd4, 2'd3);

    // R5 full queue stalls without dropping
    for (int i = 0; i < 9; i++) push_uni(32'(i + 1) << 12);
    for (int i = 0; i < 8; i++) do_wr(1'b0, 2'd0, 32'hB000_0000 + 32'(i));
    #1;
    chk(req_level_o == 4'd8, "R8 level full", req_level_o, 8);
    fork
      do_wr(1'b0, 2'd0, 32'hB000_0008);
      begin
        repeat (3) @(negedge clk_i);
        #2;
        chk(wr_ready_o == 0 && req_level_o == 4'd8, "R5 stalled while full",
            {wr_ready_o, req_level_o}, 8);
        pop_chk("R5 head", 2'd0, 32'hB000_0000, 32'h0000_1000, 1, 1, 3'd1, 0,
                32'h0000_1000, 5'd1, 2'd0);
      end
    join
    for (int i = 1; i < 9; i++)
      pop_chk("R5 tail", 2'd0, 32'hB000_0000 + 32'(i), 32'(i + 1) << 12, 1, 1, 3'd1, 0,
              32'(i + 1) << 12, 5'd1, 2'd0);

    // R7 per-thread share in dual mode
    dual_i = 1'b1;
    for (int i = 0; i < 5; i++) push_uni(32'h0010_0000);
    for (int i = 0; i < 4; i++) do_wr(1'b0, 2'd0, 32'hC000_0000 + 32'(i));
    @(negedge clk_i);
    wr_valid_i = 1'b1; wr_thread_i = 1'b0; wr_sel_i = 2'd0; wr_data_i = 32'hDEAD;
    #1;
    chk(wr_ready_o == 0, "R7 thread0 capped at half", wr_ready_o, 0);
    @(negedge clk_i);
    wr_thread_i = 1'b1; wr_data_i = 32'hC100_0000;
    #1;
    chk(wr_ready_o == 1, "R7 other thread accepted", wr_ready_o, 1);
    @(posedge clk_i); #1;
    wr_valid_i = 1'b0;
    for (int i = 0; i < 4; i++)
      pop_chk("R7 t0", 2'd0, 32'hC000_0000 + 32'(i), 32'h0010_0000, 1, 1, 3'd1, 0,
              32'h0010_0000, 5'd1, 2'd0);
    pop_chk("R7 t1", 2'd0, 32'hC100_0000, 32'h0010_0000, 1, 1, 3'd1, 1,
            32'h0010_0000, 5'd1, 2'd0);
    dual_i = 1'b0;

    // R10 interleaved threads
    wa = 32'hAAAA_A402; wb = 32'h5555_5807;
    push_uni(wa); push_uni(wb); push_uni(32'h1111_1111); push_uni(32'h2222_2222);
    do_wr(1'b0, 2'd1, 32'h10);
    do_wr(1'b1, 2'd1, 32'h20);
    do_wr(1'b1, 2'd0, 32'h21);
    do_wr(1'b0, 2'd0, 32'h11);
    pop_chk("R10 e0", 2'd1, 32'h10, wa, 1, 0, 3'd1, 0, 32'hAAAA_A000, 5'd3, 2'd1);
    pop_chk("R10 e1", 2'd1, 32'h20, wb, 1, 0, 3'd1, 1, 32'h5555_5000, 5'd8, 2'd2);
    pop_chk("R10 e2", 2'd0, 32'h21, 32'h1111_1111, 0, 1, 3'd2, 1, 32'h5555_5000, 5'd8, 2'd2);
    pop_chk("R10 e3", 2'd0, 32'h11, 32'h2222_2222, 0, 1, 3'd2, 0, 32'hAAAA_A000, 5'd3, 2'd1);
    #1;
    chk(req_valid_o == 0 && req_level_o == 0, "R8 empty after drain", req_level_o, 0);

    // R9 responses returned oldest first; response model tags each word
    for (int i = 0; i < 9; i++) begin
      @(negedge clk_i);
      rsp_valid_i = 1'b1;
      rsp_data_i  = 32'hF0F0_0000 ^ 32'(i * 257);
      #1;
      chk(rsp_ready_o == (i < 8), "R9 response room", rsp_ready_o, i < 8);
      @(posedge clk_i); #1;
      rsp_valid_i = 1'b0;
    end
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i); #1;
      chk(rd_valid_o == 1 && rd_data_o == (32'hF0F0_0000 ^ 32'(i * 257)), "R9 oldest response",
          rd_data_o, 32'hF0F0_0000 ^ 32'(i * 257));
      rd_i = 1'b1;
      @(posedge clk_i); #1;
      rd_i = 1'b0;
    end
    @(negedge clk_i); #1;
    chk(rd_valid_o == 0, "R9 empty after reads", rd_valid_o, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule